// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide engine of a small in-order integer core. It owns a pair of 32-bit result registers, HI and LO, which together form a 64-bit accumulator. The core hands it a 5-bit operation code, two 32-bit operands and a one-cycle start strobe. The block answers with a busy flag and a registered 32-bit read result that carries a one-cycle valid pulse.

The block supports several kinds of operation. Multiplies fill HI:LO with the full 64-bit product. Divides place the remainder in HI and the quotient in LO. Multiply-accumulate operations add the product to the 64-bit HI:LO value, or subtract it, and write the sum back. A three-operand multiply returns only the low product word and leaves HI and LO untouched. Move operations copy an operand into HI or LO, or read HI or LO back.

Multiplies take a fixed number of cycles, set by `MUL_LAT`. Divides are iterative and produce one quotient bit per cycle. A read of HI or LO that arrives during a long operation is held inside the block and answered once the operation has finished. The core's register file and exception handling sit outside this block.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy` and `rd_valid` are low, and HI and LO both read back as zero.
- R2: Code 0x11 writes `src_a` into HI and code 0x13 writes `src_a` into LO, both at the accepting edge and without raising `busy`. Code 0x10 returns HI and code 0x12 returns LO on `rd_data`, with `rd_valid` high for exactly the cycle after the request.
- R3: Code 0x18 (signed) and code 0x19 (unsigned) multiply `src_a` by `src_b`. HI receives product bits 63:32 and LO receives bits 31:0. `busy` stays high for exactly `MUL_LAT` cycles after the accepting edge (3 by default).
- R4: Code 0x1A (signed) and code 0x1B (unsigned) divide `src_a` by `src_b`. The remainder goes to HI and the quotient to LO. `busy` stays high for exactly 32 cycles. A signed quotient is truncated toward zero, and the remainder takes the sign of the dividend.
- R5: Codes 0x00 (signed) and 0x01 (unsigned) add the 64-bit product to HI:LO. Codes 0x04 (signed) and 0x05 (unsigned) subtract it. Both wrap modulo 2^64, with the same latency as R3.
- R6: Code 0x02 multiplies signed operands. After `MUL_LAT` busy cycles it drives the low 32 product bits on `rd_data` with a single `rd_valid` pulse. HI and LO are left unchanged.
- R7: A read request (0x10 or 0x12) made while a multiply or divide is running is held. It is answered in the cycle after the operation ends, with the updated register value. `busy` stays high through that one extra cycle.
- R8: Any other start request made while `busy` is high is ignored, and so is any code not listed above. Neither changes HI, LO or the read output.
- R9: A divide by zero ends after the same 32 busy cycles with no trap. HI and LO then hold values that are defined but unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled on each rising edge |
| op | input | 5 | Operation code |
| src_a | input | 32 | First operand; data source for moves into HI or LO |
| src_b | input | 32 | Second operand |
| busy | output | 1 | A multiply, divide or held read is in progress |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` as valid |
| rd_data | output | 32 | Read result for HI, LO or the three-operand multiply |

## Verification
The only view into HI and LO is through the read path, so a corrupted accumulator or divider bit stays hidden until the next move-from. It then appears one cycle after the request, or one cycle after a running operation ends. A fault in the cycle counter or the sequencing state shows up straight away as a change in the number of `busy` cycles. The bench therefore compares `busy` and `rd_valid` on every cycle, and compares `rd_data` on every valid pulse. Reads are placed directly after each accumulate, divide and ignored request, so that any corruption is exposed within a few cycles of its cause.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    // Operation codes; the numeric values are decoded by the issuing core.
    typedef enum logic [4:0] {
        OP_MADD   = 5'h00,
        OP_MADDU  = 5'h01,
        OP_MULGPR = 5'h02,
        OP_MSUB   = 5'h04,
        OP_MSUBU  = 5'h05,
        OP_MFHI   = 5'h10,
        OP_MTHI   = 5'h11,
        OP_MFLO   = 5'h12,
        OP_MTLO   = 5'h13,
        OP_MULT   = 5'h18,
        OP_MULTU  = 5'h19,
        OP_DIV    = 5'h1A,
        OP_DIVU   = 5'h1B
    } md_op_e;

    typedef enum logic [2:0] {
        CL_NONE,
        CL_READ,
        CL_WRITE,
        CL_MUL,
        CL_ACC,
        CL_GPR,
        CL_DIV
    } md_class_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_DIV
    } md_state_e;

    typedef struct packed {
        md_class_e cls;
        logic      sgn;     // operands are two's complement
        logic      lo_sel;  // move targets LO rather than HI
        logic      sub;     // accumulate subtracts the product
    } md_dec_t;

    function automatic md_dec_t md_decode(input logic [4:0] code);
        md_dec_t d;
        d = '{cls: CL_NONE, sgn: 1'b0, lo_sel: 1'b0, sub: 1'b0};
        case (code)
            OP_MADD:   begin d.cls = CL_ACC;   d.sgn = 1'b1; end
            OP_MADDU:  begin d.cls = CL_ACC;                 end
            OP_MSUB:   begin d.cls = CL_ACC;   d.sgn = 1'b1; d.sub = 1'b1; end
            OP_MSUBU:  begin d.cls = CL_ACC;   d.sub = 1'b1; end
            OP_MULGPR: begin d.cls = CL_GPR;   d.sgn = 1'b1; end
            OP_MFHI:   begin d.cls = CL_READ;                end
            OP_MFLO:   begin d.cls = CL_READ;  d.lo_sel = 1'b1; end
            OP_MTHI:   begin d.cls = CL_WRITE;               end
            OP_MTLO:   begin d.cls = CL_WRITE; d.lo_sel = 1'b1; end
            OP_MULT:   begin d.cls = CL_MUL;   d.sgn = 1'b1; end
            OP_MULTU:  begin d.cls = CL_MUL;                 end
            OP_DIV:    begin d.cls = CL_DIV;   d.sgn = 1'b1; end
            OP_DIVU:   begin d.cls = CL_DIV;                 end
            default:   d.cls = CL_NONE;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           sgn,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    logic [W-1:0]   a_q, b_q;
    logic           s_q;
    logic [2*W-1:0] ext_a, ext_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
            s_q <= 1'b0;
        end else if (load) begin
            a_q <= a;
            b_q <= b;
            s_q <= sgn;
        end
    end

    // Sign- or zero-extend to 2W bits; the low 2W bits of the product are exact.
    always_comb begin
        ext_a = {{W{s_q & a_q[W-1]}}, a_q};
        ext_b = {{W{s_q & b_q[W-1]}}, b_q};
        prod  = ext_a * ext_b;
    end
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o
);
    logic [W-1:0] rem_q, quo_q, dvs_q;
    logic         qneg_q, rneg_q;
    logic [W:0]   trial;
    logic [W-1:0] diff_lo, rem_n, quo_n;
    logic         ge;

    function automatic logic [W-1:0] magnitude(input logic [W-1:0] x, input logic s);
        return (s && x[W-1]) ? (~x + 1'b1) : x;
    endfunction

    // One restoring step: shift in the next dividend bit, subtract when it fits.
    always_comb begin
        trial   = {rem_q, quo_q[W-1]};
        ge      = (trial >= {1'b0, dvs_q});
        diff_lo = trial[W-1:0] - dvs_q;
        rem_n   = ge ? diff_lo : trial[W-1:0];
        quo_n   = {quo_q[W-2:0], ge};
        quot_o  = qneg_q ? (~quo_n + 1'b1) : quo_n;
        rem_o   = rneg_q ? (~rem_n + 1'b1) : rem_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dvs_q  <= '0;
            qneg_q <= 1'b0;
            rneg_q <= 1'b0;
        end else if (load) begin
            rem_q  <= '0;
            quo_q  <= magnitude(dividend, sgn);
            dvs_q  <= magnitude(divisor, sgn);
            qneg_q <= sgn & (dividend[W-1] ^ divisor[W-1]);
            rneg_q <= sgn & dividend[W-1];
        end else if (step) begin
            rem_q <= rem_n;
            quo_q <= quo_n;
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W       = 32,
    parameter int MUL_LAT = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [4:0]   op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         rd_valid,
    output logic [W-1:0] rd_data
);
    localparam int DIV_STEPS = W;
    localparam int CNT_MAX   = (DIV_STEPS > MUL_LAT) ? DIV_STEPS : MUL_LAT;
    localparam int CW        = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1;

    md_state_e      state_q;
    md_class_e      cls_q;
    logic           sub_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   hi_q, lo_q;
    logic           pend_q, pend_lo_q;
    logic           rd_valid_q;
    logic [W-1:0]   rd_data_q;

    md_dec_t        dec;
    logic           idle, accept, mul_load, div_load, div_step;
    logic [2*W-1:0] prod, acc, res;
    logic [W-1:0]   dquo, drem;

    always_comb begin
        dec      = md_decode(op);
        idle     = (state_q == ST_IDLE);
        accept   = start && idle && !pend_q;
        mul_load = accept && (dec.cls inside {CL_MUL, CL_ACC, CL_GPR});
        div_load = accept && (dec.cls == CL_DIV);
        div_step = (state_q == ST_DIV);
    end

    muldiv_mul_core #(.W(W)) u_mul (
        .clk  (clk),
        .rst  (rst),
        .load (mul_load),
        .sgn  (dec.sgn),
        .a    (src_a),
        .b    (src_b),
        .prod (prod)
    );

    muldiv_div_core #(.W(W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .load     (div_load),
        .step     (div_step),
        .sgn      (dec.sgn),
        .dividend (src_a),
        .divisor  (src_b),
        .quot_o   (dquo),
        .rem_o    (drem)
    );

    // HI:LO value to commit when the running operation finishes.
    always_comb begin
        acc = {hi_q, lo_q};
        case (cls_q)
            CL_MUL:  res = prod;
            CL_ACC:  res = sub_q ? (acc - prod) : (acc + prod);
            CL_DIV:  res = {drem, dquo};
            default: res = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cls_q      <= CL_NONE;
            sub_q      <= 1'b0;
            cnt_q      <= '0;
            hi_q       <= '0;
            lo_q       <= '0;
            pend_q     <= 1'b0;
            pend_lo_q  <= 1'b0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            if (idle) begin
                if (pend_q) begin
                    pend_q     <= 1'b0;
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= pend_lo_q ? lo_q : hi_q;
                end else if (start) begin
                    case (dec.cls)
                        CL_READ: begin
                            rd_valid_q <= 1'b1;
                            rd_data_q  <= dec.lo_sel ? lo_q : hi_q;
                        end
                        CL_WRITE: begin
                            if (dec.lo_sel) lo_q <= src_a;
                            else            hi_q <= src_a;
                        end
                        CL_MUL, CL_ACC, CL_GPR: begin
                            state_q <= ST_MUL;
                            cls_q   <= dec.cls;
                            sub_q   <= dec.sub;
                            cnt_q   <= CW'(MUL_LAT - 1);
                        end
                        CL_DIV: begin
                            state_q <= ST_DIV;
                            cls_q   <= CL_DIV;
                            sub_q   <= 1'b0;
                            cnt_q   <= CW'(DIV_STEPS - 1);
                        end
                        default: ;
                    endcase
                end
            end else begin
                if (start && dec.cls == CL_READ && !pend_q) begin
                    pend_q    <= 1'b1;
                    pend_lo_q <= dec.lo_sel;
                end
                if (cnt_q == '0) begin
                    state_q <= ST_IDLE;
                    if (cls_q == CL_GPR) begin
                        rd_valid_q <= 1'b1;
                        rd_data_q  <= prod[W-1:0];
                    end else begin
                        hi_q <= res[2*W-1:W];
                        lo_q <= res[W-1:0];
                    end
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    assign busy     = !idle || pend_q;
    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic [4:0]   op,
    input logic [W-1:0] src_a,
    input logic         busy,
    input logic         rd_valid,
    input logic [W-1:0] hi_q
);
    logic        in_div;
    logic [15:0] run_cnt;

    // Busy-cycle counter for an accepted divide, independent of the unit's own counter.
    always_ff @(posedge clk) begin
        if (rst) begin
            in_div  <= 1'b0;
            run_cnt <= '0;
        end else if (start && !busy && (op == OP_DIV || op == OP_DIVU)) begin
            in_div  <= 1'b1;
            run_cnt <= 16'd1;
        end else if (busy) begin
            run_cnt <= run_cnt + 16'd1;
        end else begin
            in_div  <= 1'b0;
            run_cnt <= '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !rd_valid));

    // R2
    read_reply_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op == OP_MFHI || op == OP_MFLO)) |=> rd_valid);

    // R2
    hi_write_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && op == OP_MTHI) |=> (hi_q == $past(src_a)));

    // R3
    mul_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (op == OP_MULT || op == OP_MULTU)) |=> busy);

    // R4
    div_len_max_chk: assert property (@(posedge clk) disable iff (rst)
        (in_div && busy) |-> (run_cnt <= 16'(W + 1)));

    // R9
    div_len_min_chk: assert property (@(posedge clk) disable iff (rst)
        (in_div && $fell(busy)) |-> (run_cnt == 16'(W + 1) || run_cnt == 16'(W + 2)));
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .op       (op),
    .src_a    (src_a),
    .busy     (busy),
    .rd_valid (rd_valid),
    .hi_q     (hi_q)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb_top;
    localparam int W       = 32;
    localparam int MUL_LAT = 3;
    localparam int DIV_LAT = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [4:0]   op = 5'h0;
    logic [W-1:0] src_a = '0;
    logic [W-1:0] src_b = '0;
    logic         busy, rd_valid;
    logic [W-1:0] rd_data;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    always #2 clk = ~clk;

    muldiv_unit #(.W(W), .MUL_LAT(MUL_LAT)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .op       (op),
        .src_a    (src_a),
        .src_b    (src_b),
        .busy     (busy),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // ---------------- behavioural reference ----------------
    bit [31:0] m_hi, m_lo, m_rd, r_hi, r_lo, r_rd;
    bit        m_uhi, m_ulo, r_unk, r_gpr, m_rd_unk;
    bit        m_pend, m_plo, m_rdv, m_busy;
    int        m_left;

    function automatic bit [63:0] ref_mul(input bit [31:0] a, input bit [31:0] b, input bit s);
        bit [63:0] ea, eb;
        ea = s ? {{32{a[31]}}, a} : {32'b0, a};
        eb = s ? {{32{b[31]}}, b} : {32'b0, b};
        return ea * eb;
    endfunction

    function automatic bit [63:0] ref_div(input bit [31:0] a, input bit [31:0] b, input bit s);
        longint x, y, q, r;
        x = s ? longint'($signed(a)) : longint'({32'b0, a});
        y = s ? longint'($signed(b)) : longint'({32'b0, b});
        if (y == 0) return 64'h0;
        q = x / y;
        r = x % y;
        return {r[31:0], q[31:0]};
    endfunction

    always @(posedge clk) begin
        bit [63:0] t;
        m_rdv = 1'b0;
        if (rst) begin
            m_hi = 0; m_lo = 0; m_uhi = 0; m_ulo = 0;
            m_left = 0; m_pend = 0; m_plo = 0;
        end else if (m_left > 0) begin
            if (start && (op == 5'h10 || op == 5'h12) && !m_pend) begin
                m_pend = 1'b1;
                m_plo  = (op == 5'h12);
            end
            m_left--;
            if (m_left == 0) begin
                if (r_gpr) begin
                    m_rdv = 1'b1; m_rd = r_rd; m_rd_unk = 1'b0;
                end else begin
                    m_hi = r_hi; m_lo = r_lo; m_uhi = r_unk; m_ulo = r_unk;
                end
            end
        end else if (m_pend) begin
            m_pend = 1'b0;
            m_rdv = 1'b1;
            m_rd = m_plo ? m_lo : m_hi;
            m_rd_unk = m_plo ? m_ulo : m_uhi;
        end else if (start) begin
            r_gpr = 1'b0; r_unk = 1'b0;
            case (op)
                5'h10: begin m_rdv = 1; m_rd = m_hi; m_rd_unk = m_uhi; end
                5'h12: begin m_rdv = 1; m_rd = m_lo; m_rd_unk = m_ulo; end
                5'h11: begin m_hi = src_a; m_uhi = 0; end
                5'h13: begin m_lo = src_a; m_ulo = 0; end
                5'h18, 5'h19: begin
                    t = ref_mul(src_a, src_b, op == 5'h18);
                    {r_hi, r_lo} = t; m_left = MUL_LAT;
                end
                5'h00, 5'h01, 5'h04, 5'h05: begin
                    t = ref_mul(src_a, src_b, op[0] == 1'b0);
                    if (op[2]) {r_hi, r_lo} = {m_hi, m_lo} - t;
                    else       {r_hi, r_lo} = {m_hi, m_lo} + t;
                    r_unk = m_uhi | m_ulo;
                    m_left = MUL_LAT;
                end
                5'h02: begin
                    t = ref_mul(src_a, src_b, 1'b1);
                    r_rd = t[31:0]; r_gpr = 1'b1; m_left = MUL_LAT;
                end
                5'h1A, 5'h1B: begin
                    {r_hi, r_lo} = ref_div(src_a, src_b, op == 5'h1A);
                    r_unk = (src_b == 0);
                    m_left = DIV_LAT;
                end
                default: ;
            endcase
        end
        m_busy = (m_left > 0) || m_pend;
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (busy !== m_busy) begin
                fails++;
                $display("FAIL %s busy act=%0b exp=%0b t=%0t", tag, busy, m_busy, $time);
            end
            checks++;
            if (rd_valid !== m_rdv) begin
                fails++;
                $display("FAIL %s rd_valid act=%0b exp=%0b t=%0t", tag, rd_valid, m_rdv, $time);
            end
            if (m_rdv && !m_rd_unk) begin
                checks++;
                if (rd_data !== m_rd) begin
                    fails++;
                    $display("FAIL %s rd_data act=%h exp=%h t=%0t", tag, rd_data, m_rd, $time);
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input logic [4:0] o, input logic [31:0] a, input logic [31:0] b);
        start = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic settle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_both();
        issue(5'h10, 0, 0);
        issue(5'h12, 0, 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        tag = "R1";                          // reset values
        read_both();

        tag = "R2";                          // moves
        issue(5'h11, 32'h1234_5678, 0);
        issue(5'h13, 32'h9ABC_DEF0, 0);
        read_both();

        tag = "R3";                          // full multiplies
        issue(5'h18, 32'hFFFF_FFFD, 32'd7); settle(); read_both();
        issue(5'h19, 32'hFFFF_FFFF, 32'hFFFF_FFFF); settle(); read_both();
        issue(5'h18, 32'h8000_0000, 32'h8000_0000); settle(); read_both();

        tag = "R5";                          // accumulate
        issue(5'h11, 32'h0, 0);
        issue(5'h13, 32'hFFFF_FFF0, 0);
        issue(5'h01, 32'h10, 32'h1); settle(); read_both();
        issue(5'h00, 32'hFFFF_FFFE, 32'd3); settle(); read_both();
        issue(5'h04, 32'hFFFF_FFFE, 32'd3); settle(); read_both();
        issue(5'h05, 32'hFFFF_FFFF, 32'd2); settle(); read_both();

        tag = "R6";                          // GPR-only multiply
        issue(5'h02, 32'hFFFF_FFFB, 32'd6); settle(); read_both();

        tag = "R4";                          // divides
        issue(5'h1A, 32'hFFFF_FFF9, 32'd2); settle(); read_both();
        issue(5'h1A, 32'd7, 32'hFFFF_FFFE); settle(); read_both();
        issue(5'h1B, 32'hFFFF_FFFF, 32'd10); settle(); read_both();
        issue(5'h1A, 32'h8000_0000, 32'hFFFF_FFFF); settle(); read_both();
        issue(5'h1B, 32'd5, 32'd9); settle(); read_both();

        tag = "R7";                          // held reads
        issue(5'h1A, 32'd100, 32'd7);
        issue(5'h12, 0, 0);
        settle();
        issue(5'h19, 32'd9, 32'd11);
        issue(5'h10, 0, 0);
        settle();

        tag = "R8";                          // ignored requests
        issue(5'h1B, 32'd50, 32'd3);
        issue(5'h18, 32'd99, 32'd99);
        issue(5'h11, 32'hDEAD_BEEF, 0);
        settle();
        read_both();
        issue(5'h07, 32'h1111_1111, 32'h2);
        issue(5'h1F, 32'h2222_2222, 32'h3);
        @(negedge clk);
        read_both();

        tag = "R9";                          // divide by zero
        issue(5'h1A, 32'd123, 32'd0); settle();
        issue(5'h1B, 32'd0, 32'd0); settle();
        issue(5'h11, 32'hA5A5_0001, 0);
        issue(5'h13, 32'h5A5A_0002, 0);
        read_both();

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog %s act=hung exp=finished", tag);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule